// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block stands between a handful of external interrupt and control pins and the pending-interrupt state of a processor core. Every pin is first brought into the core clock domain by a synchroniser. It is then compared against a stored copy of the last level the block acted on. Only a real change of level produces an event. What the event does depends on the pin's type:

- A level-sensitive pin sets or clears its own pending bit.
- The machine-check pin reacts to a falling edge only, and its pending bit stays set.
- The checkstop pin drives a halt request to the core directly.
- The hard-reset pin is tracked but has no effect.
- Pin lanes that carry no defined function are ignored entirely.

The core sees a pending vector and a summary request that is high whenever any pending bit is set. The core retires a pending interrupt through a per-bit acknowledge input. If a new set and an acknowledge hit the same bit in the same cycle, the set takes priority.

Top module: `irqpin_cond`

## Requirements
- R1: After reset, pend_o is 0, irq_o is 0 and halt_o is 0.
- R2: A pin sample equal to the level last acted on for that lane produces no event: pend_o and halt_o are unchanged by repeated identical samples.
- R3: Pin lane 0 (external interrupt) and lane 1 (system management) are active-high level pins. A rise sets pending bit 0 or bit 1 respectively, and a fall clears that bit.
- R4: Pin lane 2 (machine check) sets pending bit 2 on a 1-to-0 change only. A 0-to-1 change leaves pend_o unchanged, and the bit stays set after the pin returns high.
- R5: halt_o follows pin lane 3 (checkstop): it is 1 while the lane is high and 0 after the lane falls.
- R6: Pending bit 3 (soft reset) follows pin lane 5. It is set on a rise and cleared on a fall.
- R7: irq_o is 1 exactly when pend_o is non-zero. Clearing one bit while another is still set keeps irq_o at 1.
- R8: ack_i[b] clears pending bit b, including the machine-check bit 2. A set of bit b in the same cycle as ack_i[b] leaves the bit set.
- R9: Pin lane 4 (hard reset) and every lane at index 6 or above have no effect on pend_o, irq_o or halt_o.
- R10: A pin change applied before clock edge k shows on pend_o, irq_o and halt_o right after edge k+SYNC_STAGES. With the default of 2 stages this is the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Raw pin levels, lane index as listed in the requirements |
| ack_i | input | 4 | Per-bit clear of the pending vector from the core |
| pend_o | output | 4 | Pending vector: bit 0 external, 1 system management, 2 machine check, 3 soft reset |
| irq_o | output | 1 | Summary request, OR of the pending vector |
| halt_o | output | 1 | Halt request to the core |

## Verification
The bench builds the block with its default of eight pin lanes and two synchroniser stages. The two spare lanes, 6 and 7, put the undefined-index case within reach, next to the defined-but-inert hard-reset lane. Every lane is walked through rise, repeated high, fall and repeated low against an arithmetic model of the pending vector and halt. A run of multi-lane patterns then changes several pins in the same cycle. The bench also times the three-edge latency, and it lines up an acknowledge with a machine-check set in one cycle to show the set wins.

// File: rtl/irqpin_pkg.sv
package irqpin_pkg;

    // Pending vector layout (decoded by the core)
    localparam int PEND_W  = 4;
    localparam int PB_EXT  = 0;
    localparam int PB_SMI  = 1;
    localparam int PB_MCK  = 2;
    localparam int PB_SRST = 3;

    // Pin lane assignment
    localparam int PIN_EXT   = 0;
    localparam int PIN_SMI   = 1;
    localparam int PIN_MCK   = 2;
    localparam int PIN_STOP  = 3;
    localparam int PIN_HRST  = 4;
    localparam int PIN_SRST  = 5;
    localparam int PIN_KNOWN = 6;   // lanes at this index and above are undefined

    typedef struct packed {
        logic [PEND_W-1:0] set;
        logic [PEND_W-1:0] clr;
        logic              halt_upd;
        logic              halt_val;
    } pin_evt_t;

endpackage

// File: rtl/irqpin_sync.sv
module irqpin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/irqpin_decode.sv
module irqpin_decode
    import irqpin_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] lvl_i,
    output pin_evt_t            evt_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] last;
    } dec_st_t;

    dec_st_t             st_d, st_q;
    logic [NUM_PINS-1:0] known;
    logic [NUM_PINS-1:0] chg;

    // Lanes with a defined function; others never update their stored level
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_known
        if (i < PIN_KNOWN) begin : g_def
            assign known[i] = 1'b1;
        end else begin : g_undef
            assign known[i] = 1'b0;
        end
    end

    assign chg = (lvl_i ^ st_q.last) & known;

    always_comb begin
        st_d      = st_q;
        st_d.last = (st_q.last & ~chg) | (lvl_i & chg);

        evt_o = '0;
        // level pins, active high
        evt_o.set[PB_EXT]  = chg[PIN_EXT] &  lvl_i[PIN_EXT];
        evt_o.clr[PB_EXT]  = chg[PIN_EXT] & ~lvl_i[PIN_EXT];
        evt_o.set[PB_SMI]  = chg[PIN_SMI] &  lvl_i[PIN_SMI];
        evt_o.clr[PB_SMI]  = chg[PIN_SMI] & ~lvl_i[PIN_SMI];
        // machine check: falling edge only, never cleared by the pin
        evt_o.set[PB_MCK]  = chg[PIN_MCK] & ~lvl_i[PIN_MCK];
        // soft reset follows its pin
        evt_o.set[PB_SRST] = chg[PIN_SRST] &  lvl_i[PIN_SRST];
        evt_o.clr[PB_SRST] = chg[PIN_SRST] & ~lvl_i[PIN_SRST];
        // checkstop drives halt; hard-reset lane is tracked only
        evt_o.halt_upd     = chg[PIN_STOP];
        evt_o.halt_val     = lvl_i[PIN_STOP];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: unchanged samples raise no event
    p_quiet_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((lvl_i & known) == (st_q.last & known)) |->
            (evt_o.set == '0 && evt_o.clr == '0 && !evt_o.halt_upd));

    // R4: a rising machine-check lane sets nothing
    p_mck_rise_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_i[PIN_MCK] && !st_q.last[PIN_MCK]) |-> !evt_o.set[PB_MCK]);

    // R9: undefined lanes keep their stored level
    for (genvar u = PIN_KNOWN; u < NUM_PINS; u++) begin : g_undef_chk
        p_undef_stable_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            1'b1 |=> $stable(st_q.last[u]));
    end

endmodule

// File: rtl/irqpin_pend.sv
module irqpin_pend
    import irqpin_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  pin_evt_t          evt_i,
    input  logic [PEND_W-1:0] ack_i,
    output logic [PEND_W-1:0] pend_o,
    output logic              irq_o,
    output logic              halt_o
);

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic              irq;
        logic              halt;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // set dominates both pin clears and core acknowledges
        st_d.pend = (st_q.pend & ~ack_i & ~evt_i.clr) | evt_i.set;
        st_d.irq  = |st_d.pend;
        if (evt_i.halt_upd) begin
            st_d.halt = evt_i.halt_val;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;
    assign halt_o = st_q.halt;

    for (genvar b = 0; b < PEND_W; b++) begin : g_bit_chk
        // R8: set wins over a same-cycle acknowledge
        p_set_wins_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt_i.set[b] |=> st_q.pend[b]);
        // R8: acknowledge clears when no set competes
        p_ack_clears_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ack_i[b] && !evt_i.set[b]) |=> !st_q.pend[b]);
    end

    // R7: summary request matches the vector
    p_irq_sum_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.irq == (st_q.pend != '0));

    // R2: no event and no acknowledge keeps the vector
    p_hold_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i.set == '0 && evt_i.clr == '0 && ack_i == '0) |=> $stable(st_q.pend));

    // R5: halt only moves on a checkstop change
    p_halt_hold_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !evt_i.halt_upd |=> $stable(st_q.halt));

endmodule

// File: rtl/irqpin_cond.sv
module irqpin_cond
    import irqpin_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [PEND_W-1:0]   ack_i,
    output logic [PEND_W-1:0]   pend_o,
    output logic                irq_o,
    output logic                halt_o
);

    logic [NUM_PINS-1:0] lvl_sync;
    pin_evt_t            evt;

    irqpin_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (pins_i),
        .dout_o (lvl_sync)
    );

    irqpin_decode #(
        .NUM_PINS (NUM_PINS)
    ) i_decode (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl_sync),
        .evt_o  (evt)
    );

    irqpin_pend i_pend (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (evt),
        .ack_i  (ack_i),
        .pend_o (pend_o),
        .irq_o  (irq_o),
        .halt_o (halt_o)
    );

    // R4: machine-check bit never drops without an acknowledge
    p_mck_sticky_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(pend_o[PB_MCK]) && !$past(ack_i[PB_MCK])) |-> pend_o[PB_MCK]);

endmodule

// File: tb/test_irqpin_cond.sv
module test_irqpin_cond;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pins;
    logic [3:0]    ack;
    logic [3:0]    pend_o;
    logic          irq_o;
    logic          halt_o;

    int checks = 0;
    int errors = 0;

    logic [5:0] m_last;
    logic [3:0] m_pend;
    logic       m_halt;

    always #2.5 clk = ~clk;

    irqpin_cond #(.NUM_PINS(NP), .SYNC_STAGES(2)) i_irqpin_cond (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .pins_i (pins),
        .ack_i  (ack),
        .pend_o (pend_o),
        .irq_o  (irq_o),
        .halt_o (halt_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag);
        checks++;
        if (pend_o !== m_pend) begin
            errors++;
            $display("FAIL %s pend_o actual=%b expected=%b", tag, pend_o, m_pend);
        end
        checks++;
        if (irq_o !== (m_pend != 4'b0)) begin
            errors++;
            $display("FAIL %s irq_o actual=%b expected=%b", tag, irq_o, (m_pend != 4'b0));
        end
        checks++;
        if (halt_o !== m_halt) begin
            errors++;
            $display("FAIL %s halt_o actual=%b expected=%b", tag, halt_o, m_halt);
        end
    endtask

    // Model from the requirements (R3 R4 R5 R6 R9)
    task automatic model_pins(input logic [NP-1:0] v);
        for (int i = 0; i < 6; i++) begin
            if (v[i] != m_last[i]) begin
                case (i)
                    0: m_pend[0] = v[i];
                    1: m_pend[1] = v[i];
                    2: if (!v[i]) m_pend[2] = 1'b1;
                    3: m_halt = v[i];
                    5: m_pend[3] = v[i];
                    default: ;
                endcase
                m_last[i] = v[i];
            end
        end
    endtask

    task automatic apply(input logic [NP-1:0] v, input string tag);
        pins = v;
        model_pins(v);
        step(3);
        check(tag);
    endtask

    task automatic ack_bits(input logic [3:0] a, input string tag);
        ack = a;
        step(1);
        ack = 4'b0;
        m_pend = m_pend & ~a;
        step(1);
        check(tag);
    endtask

    function automatic string lane_tag(input int p);
        case (p)
            0, 1:    return "R3";
            2:       return "R4";
            3:       return "R5";
            5:       return "R6";
            default: return "R9";
        endcase
    endfunction

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [NP-1:0] cur;
        logic [1:0]    seq [6];
        rst_n  = 1'b0;
        pins   = '0;
        ack    = '0;
        m_last = '0;
        m_pend = '0;
        m_halt = 1'b0;
        step(3);
        check("R1");
        rst_n = 1'b1;
        step(2);
        check("R1");

        // Per-lane sweep: rise, repeat, fall, repeat, rise, fall
        seq[0] = 2'd1; seq[1] = 2'd1; seq[2] = 2'd0;
        seq[3] = 2'd0; seq[4] = 2'd1; seq[5] = 2'd0;
        for (int p = 0; p < NP; p++) begin
            cur = '0;
            for (int s = 0; s < 6; s++) begin
                logic nb;
                logic [NP-1:0] nv;
                nb = seq[s][0];
                nv = cur;
                nv[p] = nb;
                if (nv == cur) apply(nv, "R2");
                else           apply(nv, lane_tag(p));
                cur = nv;
            end
            ack_bits(4'hF, "R8");
        end

        // R10: latency of three edges
        pins = 8'b0000_0001;
        step(2);
        check("R10");
        model_pins(8'b0000_0001);
        step(1);
        check("R10");

        // R7: partial clear keeps the summary request
        apply(8'b0000_0011, "R7");
        apply(8'b0000_0010, "R7");
        apply(8'b0000_0000, "R7");

        // R4: rising machine check sets nothing, falling sets a sticky bit
        apply(8'b0000_0100, "R4");
        apply(8'b0000_0000, "R4");
        apply(8'b0000_0100, "R4");
        ack_bits(4'b0100, "R8");

        // R8: set and acknowledge in the same cycle, set wins
        pins = 8'b0000_0000;
        model_pins(pins);
        step(2);
        ack = 4'b0100;
        step(1);
        ack = 4'b0000;
        check("R8");
        ack_bits(4'b0100, "R8");

        // R6 with R8: acknowledge clears the soft-reset bit while the lane is high
        apply(8'b0010_0000, "R6");
        ack_bits(4'b1000, "R8");
        apply(8'b0010_0000, "R2");
        apply(8'b0000_0000, "R6");

        // Multi-lane patterns
        for (int k = 0; k < 40; k++) begin
            logic [NP-1:0] v;
            v = NP'((k * 37) ^ (k >> 1) ^ (k << 3));
            apply(v, "R3");
            if (k % 7 == 6) ack_bits(4'hF, "R8");
        end
        apply('0, "R9");
        ack_bits(4'hF, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule